// File: doc/BRIEF.md
# Selectable-Ratio Word Demultiplexer with Realignment

This block accepts one word on every edge of a fast clock and distributes consecutive words across a bank of parallel output lanes. A run-time selector picks between a wide grouping, where eight consecutive words form one group, and a narrow grouping of four. Incoming words are first collected in a staging bank. When a group is complete, it is copied in one step into a separate output bank, and a ready strobe marks that copy for one clock. Downstream logic that runs at a fraction of the input rate can therefore capture a whole group in a single cycle.

A synchronisation request realigns the lane counter so that a chosen word lands in lane 0. The block only looks for the rising edge of the request, so a request that stays high acts once. When the counter already stands at lane 0, realignment changes nothing that can be seen. When the counter is elsewhere, the partial group is abandoned and the stream settles within one group latency. A new ratio is adopted only at a realignment.

The two most significant bits of each word can be put into an idle mode to save power. In that mode their storage stops toggling and their output bits read as zero.

Top module: `lane_demux`

## Requirements
- R1: While `rst_n` is low, and on the cycle after it is released, `dout` is all zero and `dready` is 0. The ratio is wide (8 lanes). The first word sampled after release goes to lane 0.
- R2: In wide mode, consecutive sampled words fill lanes 0 to 7 in ascending order. Lane `k` occupies `dout[k*10 +: 10]`. The output bank loads all eight lanes on the edge that samples the eighth word, so the lane-0 word becomes visible 7 edges after it was sampled.
- R3: In narrow mode, words fill lanes 0 to 3. The output bank loads on the edge that samples the fourth word, so the lane-0 word becomes visible 3 edges after it was sampled.
- R4: In narrow mode, the output lanes 4 to 7 keep the values they held before, through every transfer.
- R5: `dready` is 1 for exactly one cycle: the cycle that starts with the edge on which the output bank loads. It is 0 in every other cycle.
- R6: `sync_req` is registered on the clock. Its rising edge, first seen at edge A, realigns the counter at edge A+1, so the word sampled at A+1 goes to lane 0. Holding `sync_req` high for any number of cycles produces only one realignment.
- R7: If the counter would already have put the word at edge A+1 into lane 0, the realignment leaves the groups, the values and the `dready` timing unchanged.
- R8: If the counter was elsewhere, the partially collected group is dropped without a `dready`. Grouping then restarts from lane 0 with the word at A+1.
- R9: `ratio_sel` (1 = wide, 0 = narrow) is read only on the realignment edge. Changing it at any other time has no effect on the grouping.
- R10: While `upper_nap` is 1, bits 9:8 of every lane on `dout` read 0, and the stored bits 9:8 in both banks stop updating. Bits 7:0 keep working as normal.
- R11: Bits 7:0 of `dout` change only on an edge after which `dready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input word clock; the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 10 | Input word, sampled on every rising edge |
| ratio_sel | input | 1 | Ratio request: 1 selects 8 lanes, 0 selects 4 lanes; taken at realignment |
| sync_req | input | 1 | Realignment request; its rising edge is used |
| upper_nap | input | 1 | Puts bits 9:8 of the datapath into idle mode |
| dout | output | 80 | Output bank, lane k at bits k*10+9 down to k*10 |
| dready | output | 1 | One-cycle strobe marking a freshly loaded output bank |

## Verification
The properties assume a continuous word stream: every clock edge carries a valid `din`. They also assume that `upper_nap` changes only between edges, since its effect on the output bits is immediate. The stimulus changes all inputs a short delay after a rising edge. It presents a new word on every edge, without gaps.

Realignment requests in the stimulus are dropped low for several edges before they are raised again, so that each rising edge is seen. The requests are placed so that both the aligned case and the misaligned case occur, and one request is held high across many groups. The scoreboard derives the expected groups, and the edge on which each should appear, from the requirement rules alone.

// File: rtl/ldmx_pkg.sv
package ldmx_pkg;

    // Grouping ratio held by the lane controller.
    typedef enum logic {
        RATIO_NARROW = 1'b0,
        RATIO_WIDE   = 1'b1
    } ratio_e;

    // Registered history of the realignment request.
    typedef struct packed {
        logic req;
        logic prev;
    } edge_st_t;

endpackage

// File: rtl/ldmx_sync_edge.sv
module ldmx_sync_edge
    import ldmx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_o
);

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.req  = req_i;
        st_d.prev = st_q.req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // High for one cycle after the request is first seen high.
    assign pulse_o = st_q.req & ~st_q.prev;

endmodule

// File: rtl/ldmx_lane_ctrl.sv
module ldmx_lane_ctrl
    import ldmx_pkg::*;
#(
    parameter int LANES = 8,
    parameter int CNT_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             realign_i,
    input  logic             ratio_i,
    output logic [CNT_W-1:0] lane_o,
    output logic             load_o,
    output logic             ready_o,
    output logic             wide_o
);

    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(LANES - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(LANES / 2 - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ratio_e           mode;
        logic             ready;
    } ctrl_st_t;

    ctrl_st_t         st_d, st_q;
    ratio_e           mode_eff;
    logic [CNT_W-1:0] lane_eff;
    logic [CNT_W-1:0] lane_last;
    logic             load;

    always_comb begin
        st_d      = st_q;
        mode_eff  = realign_i ? ratio_e'(ratio_i) : st_q.mode;
        lane_eff  = realign_i ? '0 : st_q.cnt;
        lane_last = (mode_eff == RATIO_WIDE) ? LAST_WIDE : LAST_NARROW;
        load      = (lane_eff == lane_last);
        st_d.mode  = mode_eff;
        st_d.ready = load;
        st_d.cnt   = load ? '0 : lane_eff + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.mode  <= RATIO_WIDE;
            st_q.ready <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lane_o  = lane_eff;
    assign load_o  = load;
    assign ready_o = st_q.ready;
    assign wide_o  = (st_q.mode == RATIO_WIDE);

endmodule

// File: rtl/ldmx_lane_store.sv
module ldmx_lane_store #(
    parameter int WORD_W   = 10,
    parameter int NAP_BITS = 2,
    parameter int LANES    = 8,
    parameter int CNT_W    = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WORD_W-1:0]       word_i,
    input  logic [CNT_W-1:0]        lane_i,
    input  logic                    load_i,
    input  logic                    nap_i,
    output logic [LANES*WORD_W-1:0] lanes_o
);

    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t calc_up_mask();
        word_t m;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (i >= WORD_W - NAP_BITS);
        end
        return m;
    endfunction

    localparam word_t UP_MASK = calc_up_mask();

    typedef struct packed {
        word_t [LANES-1:0] stage;
        word_t [LANES-1:0] outb;
    } store_st_t;

    store_st_t st_d, st_q;
    store_st_t raw;

    // Retain the idle bits from the old value while napping.
    function automatic word_t freeze(word_t nxt, word_t cur, logic nap);
        return nap ? ((cur & UP_MASK) | (nxt & ~UP_MASK)) : nxt;
    endfunction

    always_comb begin
        raw = st_q;
        for (int l = 0; l < LANES; l++) begin
            if (CNT_W'(l) == lane_i) begin
                if (load_i) begin
                    raw.outb[l] = word_i;
                end else begin
                    raw.stage[l] = word_i;
                end
            end else if (load_i && (CNT_W'(l) < lane_i)) begin
                raw.outb[l] = st_q.stage[l];
            end
        end
        st_d = raw;
        for (int l = 0; l < LANES; l++) begin
            st_d.stage[l] = freeze(raw.stage[l], st_q.stage[l], nap_i);
            st_d.outb[l]  = freeze(raw.outb[l], st_q.outb[l], nap_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane_out
        assign lanes_o[g*WORD_W +: WORD_W] =
            nap_i ? (st_q.outb[g] & ~UP_MASK) : st_q.outb[g];
    end

endmodule

// File: rtl/lane_demux.sv
module lane_demux #(
    parameter int WORD_W   = 10,
    parameter int NAP_BITS = 2,
    parameter int LANES    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WORD_W-1:0]       din,
    input  logic                    ratio_sel,
    input  logic                    sync_req,
    input  logic                    upper_nap,
    output logic [LANES*WORD_W-1:0] dout,
    output logic                    dready
);

    localparam int CNT_W = $clog2(LANES);

    logic             realign;
    logic [CNT_W-1:0] lane_sel;
    logic             bank_load;
    logic             mode_wide;

    ldmx_sync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (sync_req),
        .pulse_o (realign)
    );

    ldmx_lane_ctrl #(
        .LANES (LANES),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .realign_i (realign),
        .ratio_i   (ratio_sel),
        .lane_o    (lane_sel),
        .load_o    (bank_load),
        .ready_o   (dready),
        .wide_o    (mode_wide)
    );

    ldmx_lane_store #(
        .WORD_W   (WORD_W),
        .NAP_BITS (NAP_BITS),
        .LANES    (LANES),
        .CNT_W    (CNT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (din),
        .lane_i  (lane_sel),
        .load_i  (bank_load),
        .nap_i   (upper_nap),
        .lanes_o (dout)
    );

endmodule

// File: rtl/ldmx_chk.sv
module ldmx_chk #(
    parameter int WORD_W   = 10,
    parameter int NAP_BITS = 2,
    parameter int LANES    = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    dready,
    input logic [LANES*WORD_W-1:0] dout,
    input logic                    upper_nap,
    input logic                    mode_wide
);

    localparam int LOW_W = WORD_W - NAP_BITS;
    localparam int HALF  = LANES / 2;

    logic [LANES*LOW_W-1:0]    low_v;
    logic [LANES*NAP_BITS-1:0] up_v;
    logic [HALF*LOW_W-1:0]     top_half_low;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign low_v[g*LOW_W +: LOW_W]      = dout[g*WORD_W +: LOW_W];
        assign up_v[g*NAP_BITS +: NAP_BITS] = dout[g*WORD_W + LOW_W +: NAP_BITS];
        if (g >= HALF) begin : g_top
            assign top_half_low[(g-HALF)*LOW_W +: LOW_W] = dout[g*WORD_W +: LOW_W];
        end
    end

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dready |=> !dready); // R5

    AST_HOLD_WITHOUT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !dready |-> $stable(low_v)); // R11

    AST_NAP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        upper_nap |-> (up_v == '0)); // R10

    AST_NARROW_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dready && !mode_wide) |-> $stable(top_half_low)); // R4

endmodule

bind lane_demux ldmx_chk #(
    .WORD_W   (WORD_W),
    .NAP_BITS (NAP_BITS),
    .LANES    (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dready    (dready),
    .dout      (dout),
    .upper_nap (upper_nap),
    .mode_wide (mode_wide)
);

// File: tb/lane_demux_test.sv
`timescale 1ns/1ps
module lane_demux_test;

    localparam int W  = 10;
    localparam int NL = 8;
    localparam logic [W-1:0]    UPM  = 10'h300;
    localparam logic [NL*W-1:0] LOWM = {NL{10'h0FF}};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [W-1:0]    din = '0;
    logic            ratio_sel = 1'b1;
    logic            sync_req = 1'b0;
    logic            upper_nap = 1'b0;
    logic [NL*W-1:0] dout;
    logic            dready;

    lane_demux uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .ratio_sel (ratio_sel),
        .sync_req  (sync_req),
        .upper_nap (upper_nap),
        .dout      (dout),
        .dready    (dready)
    );

    always #10 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // Scoreboard queues: expected bank, edge it appears on, requirement tag.
    logic [NL*W-1:0] q_data[$];
    int              q_at[$];
    string           q_tag[$];

    // Reference state built from the requirement rules.
    logic [W-1:0] m_stage[NL];
    logic [W-1:0] m_out[NL];
    int           m_cnt = 0;
    bit           m_wide = 1'b1;
    bit           m_r1 = 1'b0;
    bit           m_r2 = 1'b0;
    logic [NL*W-1:0] prev_dout = '0;

    task automatic check(input bit ok, input string tag,
                         input logic [NL*W-1:0] got, input logic [NL*W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [W-1:0] frz(logic [W-1:0] nw, logic [W-1:0] old);
        return upper_nap ? ((old & UPM) | (nw & ~UPM)) : nw;
    endfunction

    // Driver: one word per edge, model advanced on that edge.
    task automatic step(input logic [W-1:0] w, input logic s);
        bit pulse;
        bit wide_e;
        int idx;
        int last;
        logic [NL*W-1:0] pk;
        din      = w;
        sync_req = s;
        @(posedge clk);
        cyc++;
        pulse  = m_r1 && !m_r2;          // R6: rising edge acts one edge later
        m_r2   = m_r1;
        m_r1   = s;
        wide_e = pulse ? ratio_sel : m_wide;   // R9
        m_wide = wide_e;
        idx    = pulse ? 0 : m_cnt;      // R7 R8
        last   = wide_e ? NL - 1 : NL / 2 - 1;
        if (idx == last) begin
            for (int l = 0; l < idx; l++) m_out[l] = frz(m_stage[l], m_out[l]);
            m_out[idx] = frz(w, m_out[idx]);
            for (int l = 0; l < NL; l++) pk[l*W +: W] = m_out[l];
            q_data.push_back(pk);
            q_at.push_back(cyc);
            q_tag.push_back(cur_tag);
            m_cnt = 0;
        end else begin
            m_stage[idx] = frz(w, m_stage[idx]);
            m_cnt = idx + 1;
        end
        #2;
    endtask

    // Monitor: compare away from the active edge.
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (q_at.size() > 0 && q_at[0] == cyc) begin
                logic [NL*W-1:0] e;
                string t;
                e = q_data.pop_front();
                t = q_tag.pop_front();
                void'(q_at.pop_front());
                if (upper_nap) e = e & LOWM;
                check(dready === 1'b1 && dout === e, t, dout, e);
            end else begin
                check(dready === 1'b0, {"R5 ", cur_tag}, {79'b0, dready}, '0);
                check((dout & LOWM) === (prev_dout & LOWM), "R11", dout, prev_dout);
            end
            prev_dout = dout;
        end
    end

    task automatic report;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(20.0 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL R5 watchdog expired at edge %0d", cyc);
        report();
    end

    function automatic logic [W-1:0] pat(int i, int salt);
        return W'(i * 37 + salt * 101 + 3);
    endfunction

    initial begin
        for (int l = 0; l < NL; l++) begin
            m_stage[l] = '0;
            m_out[l]   = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        check(dout === '0 && dready === 1'b0, "R1 in reset", dout, '0);
        #1;
        rst_n = 1'b1;
        #1;
        check(dout === '0 && dready === 1'b0, "R1 after release", dout, '0);
        mon_on = 1'b1;

        // R1 R2: wide groups from reset, first word to lane 0
        cur_tag = "R1 R2";
        for (int i = 0; i < 16; i++) step(pat(i, 1), 1'b0);

        // R9: ratio request alone changes nothing
        cur_tag   = "R9";
        ratio_sel = 1'b0;
        for (int i = 0; i < 8; i++) step(pat(i, 2), 1'b0);

        // R6: aligned request adopts narrow ratio; held high for many groups
        cur_tag = "R6";
        for (int i = 0; i < 7; i++) step(pat(i, 3), 1'b0);
        step(pat(7, 3), 1'b1);
        cur_tag = "R3 R4 R6";
        for (int i = 0; i < 20; i++) step(pat(i, 4), 1'b1);
        for (int i = 0; i < 3; i++) step(pat(i, 5), 1'b0);

        // R7: request timed so the realigned word was heading to lane 0
        cur_tag = "R7";
        while (m_cnt != 3) step(pat(m_cnt, 6), 1'b0);
        step(pat(9, 6), 1'b1);
        for (int i = 0; i < 12; i++) step(pat(i, 7), 1'b1);
        for (int i = 0; i < 3; i++) step(pat(i, 8), 1'b0);

        // R8: misaligned request drops the partial group
        cur_tag = "R8";
        while (m_cnt != 1) step(pat(m_cnt, 9), 1'b0);
        step(pat(5, 9), 1'b1);
        for (int i = 0; i < 12; i++) step(pat(i, 10), 1'b0);

        // R9: back to wide, only after a realignment
        cur_tag   = "R9";
        ratio_sel = 1'b1;
        for (int i = 0; i < 6; i++) step(pat(i, 11), 1'b0);
        step(pat(6, 11), 1'b1);
        for (int i = 0; i < 18; i++) step(pat(i, 12), 1'b0);

        // R10: idle upper bits, then wake
        cur_tag = "R10";
        while (m_cnt != 0) step(pat(m_cnt, 13), 1'b0);
        upper_nap = 1'b1;
        for (int i = 0; i < 16; i++) step(10'h3FF ^ pat(i, 14), 1'b0);
        check((dout & ~LOWM) === '0, "R10 idle bits", dout & ~LOWM, '0);
        upper_nap = 1'b0;
        for (int i = 0; i < 16; i++) step(10'h3C0 ^ pat(i, 15), 1'b0);

        @(negedge clk);
        #1;
        check(q_at.size() == 0, "R5 all groups seen", NL*W'(q_at.size()), '0);
        report();
    end

endmodule